// File: doc/BRIEF.md
# Single-Transfer DMA Bus Sequencer

This block is a one-channel DMA engine that moves bytes between an I/O device and memory, one byte per bus tenure. When it is armed and the device raises its request, the engine asks the host processor for the bus and waits for the grant. It then drives the memory address, pulses an address latch strobe, and runs one fly-by cycle: the device is acknowledged while the memory and I/O strobes are active. After that it gives the bus back. A device that keeps its request high therefore gets one bus tenure per byte and must win arbitration again for each byte.

Software sets a 16-bit start address, a 16-bit byte count and a control word through a small write port. The address counter steps inside one 64K page and wraps from the top of the page back to zero. It never carries into page bits. Arming a transfer whose start address plus count would run past the page end raises an error flag. The transfer still runs and wraps. When the count runs out, the engine raises done and ignores further requests until it is programmed again.

Top module: `dma_single_seq`

## Requirements
- R1: While rst_n is low and after it rises, hold_req, addr_oe, addr_stb, dev_ack, mem_rd, mem_wr, io_rd, io_wr, done and bound_err are 0 and mem_addr is 0.
- R2: When the engine is armed and not done, and dev_req is sampled high while the engine is idle, hold_req rises on the next cycle. addr_oe, addr_stb, dev_ack and the four strobes stay low until hold_ack has been sampled high, however long the grant takes.
- R3: On the cycle after hold_ack is sampled high, addr_oe rises with the current address on mem_addr. On the next cycle addr_stb is high for exactly one cycle. dev_ack is then high for XFER_CLKS cycles (default 4) while the address is held.
- R4: While dev_ack is high, control bit 0 = 0 gives io_rd and mem_wr (device to memory), and control bit 0 = 1 gives mem_rd and io_wr (memory to device). No other strobe combination is driven.
- R5: hold_req is low in the cycle after the last dev_ack cycle and stays low until hold_ack has been sampled low. Every byte has its own hold_req pulse, even when dev_req stays high.
- R6: The address steps by one after each byte and wraps from 0xFFFF to 0x0000 within 16 bits. mem_addr is 0 whenever addr_oe is low.
- R7: After the programmed number of bytes, done is 1 and dev_req no longer raises hold_req. dev_req is also ignored while the engine is not armed. Arming with a count of 0 sets done at once and moves no bytes.
- R8: Arming sets bound_err when start address plus count exceeds 0x10000, and clears it otherwise. A sum of exactly 0x10000 is not flagged. A flagged transfer still moves every byte, with the address wrapping.
- R9: Register port: cfg_sel 0 writes the address, 1 writes the count, and 2 writes control (bit 0 direction, bit 1 arm). Writing control with bit 1 = 0 disarms the engine and clears done and bound_err.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | 16 | Register write data |
| dev_req | input | 1 | Device transfer request |
| dev_ack | output | 1 | Device acknowledge during the byte cycle |
| hold_req | output | 1 | Bus request to the CPU |
| hold_ack | input | 1 | Bus grant from the CPU |
| mem_addr | output | 16 | Memory address, 0 when not driven |
| addr_oe | output | 1 | Address is being driven |
| addr_stb | output | 1 | One-cycle address latch strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| done | output | 1 | Programmed count reached |
| bound_err | output | 1 | Programmed range passes the 64K page end |

## Verification
The assertions assume the CPU side behaves as a bus owner should. hold_ack rises only while hold_req is high, stays high until hold_req drops, and then falls within a cycle or two. They also assume the address, count and control registers are not rewritten while a byte is in flight. The bench models the CPU with a random grant latency that obeys these rules. It writes registers only when the engine is idle or done. It lets dev_req toggle freely, because the engine samples the request only between bytes.

// File: rtl/dma_seq_pkg.sv
// Package: shared state encoding and register-port codes for the
// single-transfer DMA sequencer. Assumes a 2-bit register select.
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_STB,
        ST_XFER,
        ST_REL
    } seq_state_t;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int CTRL_DIR_BIT = 0;
    localparam int CTRL_ARM_BIT = 1;

endpackage

// File: rtl/dma_seq_fsm.sv
// Module: bus tenure sequencer. Requests the bus for one byte, waits for
// the grant, presents the address, strobes it, holds the byte cycle for
// XFER_CLKS cycles, then releases the bus and waits for the grant to drop.
// Assumes hold_ack follows hold_req like a well-behaved bus owner.
module dma_seq_fsm
    import dma_seq_pkg::*;
#(
    parameter int XFER_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold_ack,
    output logic hold_req,
    output logic addr_oe,
    output logic addr_stb,
    output logic xfer_on,
    output logic byte_done
);

    localparam int TW = $clog2(XFER_CLKS + 1);

    seq_state_t     state;
    logic [TW-1:0]  timer;

    // Advance the tenure state and count down the byte cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            timer <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) state <= ST_REQ;
                ST_REQ:  if (hold_ack) state <= ST_ADDR;
                ST_ADDR: state <= ST_STB;
                ST_STB: begin
                    state <= ST_XFER;
                    timer <= TW'(XFER_CLKS - 1);
                end
                ST_XFER: begin
                    if (timer == '0) state <= ST_REL;
                    else             timer <= timer - 1'b1;
                end
                ST_REL:  if (!hold_ack) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode bus-side controls from the tenure state.
    always_comb begin
        hold_req  = (state == ST_REQ) || (state == ST_ADDR) ||
                    (state == ST_STB) || (state == ST_XFER);
        addr_oe   = (state == ST_ADDR) || (state == ST_STB) || (state == ST_XFER);
        addr_stb  = (state == ST_STB);
        xfer_on   = (state == ST_XFER);
        byte_done = (state == ST_XFER) && (timer == '0);
    end

endmodule

// File: rtl/dma_addr_cnt.sv
// Module: programming registers, address and count counters. The address
// wraps inside its own width (one page) and never carries outward. Arming
// checks the programmed range against the page end.
// Assumes registers are not written while a byte is in flight.
module dma_addr_cnt
    import dma_seq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          byte_done,
    output logic [AW-1:0] cur_addr,
    output logic          armed,
    output logic          dir,
    output logic          done,
    output logic          bound_err
);

    localparam logic [AW:0] PAGE_END = {1'b1, {AW{1'b0}}};

    logic [AW-1:0] cur_cnt;
    logic [AW:0]   end_sum;

    // Range end used by the page-crossing check at arm time.
    always_comb end_sum = {1'b0, cur_addr} + {1'b0, cur_cnt};

    // Register writes and per-byte counter updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_cnt   <= '0;
            armed     <= 1'b0;
            dir       <= 1'b0;
            done      <= 1'b0;
            bound_err <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_ADDR: cur_addr <= cfg_wdata;
                SEL_CNT:  cur_cnt  <= cfg_wdata;
                SEL_CTRL: begin
                    armed     <= cfg_wdata[CTRL_ARM_BIT];
                    dir       <= cfg_wdata[CTRL_DIR_BIT];
                    done      <= cfg_wdata[CTRL_ARM_BIT] && (cur_cnt == '0);
                    bound_err <= cfg_wdata[CTRL_ARM_BIT] && (end_sum > PAGE_END);
                end
                default: ;
            endcase
        end else if (byte_done) begin
            cur_addr <= cur_addr + 1'b1;
            cur_cnt  <= cur_cnt - 1'b1;
            if (cur_cnt == AW'(1)) done <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_strobe_dec.sv
// Module: fly-by strobe decoder. During the byte cycle it acknowledges the
// device and pairs the memory and I/O strobes by direction.
// Assumes dir is stable through a byte.
module dma_strobe_dec (
    input  logic xfer_on,
    input  logic dir,
    output logic dev_ack,
    output logic mem_rd,
    output logic mem_wr,
    output logic io_rd,
    output logic io_wr
);

    // Direction 0 moves device to memory, 1 moves memory to device.
    always_comb begin
        dev_ack = xfer_on;
        io_rd   = xfer_on && !dir;
        mem_wr  = xfer_on && !dir;
        mem_rd  = xfer_on && dir;
        io_wr   = xfer_on && dir;
    end

endmodule

// File: rtl/dma_single_seq.sv
// Module: top of the single-transfer DMA sequencer. It joins the register
// and counter block, the bus tenure sequencer and the strobe decoder.
// Assumes a synchronous active-low reset and one clock domain.
module dma_single_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int XFER_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              dev_req,
    output logic              dev_ack,
    output logic              hold_req,
    input  logic              hold_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              addr_oe,
    output logic              addr_stb,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              done,
    output logic              bound_err
);

    logic [ADDR_W-1:0] cur_addr;
    logic              armed;
    logic              dir;
    logic              start;
    logic              xfer_on;
    logic              byte_done;

    // A byte may begin only while armed with count remaining.
    always_comb start = armed && !done && dev_req;

    // Drive the address only while the bus is owned.
    always_comb mem_addr = addr_oe ? cur_addr : '0;

    dma_addr_cnt #(.AW(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .byte_done (byte_done),
        .cur_addr  (cur_addr),
        .armed     (armed),
        .dir       (dir),
        .done      (done),
        .bound_err (bound_err)
    );

    dma_seq_fsm #(.XFER_CLKS(XFER_CLKS)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .hold_ack  (hold_ack),
        .hold_req  (hold_req),
        .addr_oe   (addr_oe),
        .addr_stb  (addr_stb),
        .xfer_on   (xfer_on),
        .byte_done (byte_done)
    );

    dma_strobe_dec i_dec (
        .xfer_on (xfer_on),
        .dir     (dir),
        .dev_ack (dev_ack),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr),
        .io_rd   (io_rd),
        .io_wr   (io_wr)
    );

endmodule

// File: rtl/dma_seq_chk.sv
// Module: property checker for the DMA sequencer, bound into the top.
// Assumes the CPU grant follows hold_req, and that registers are written
// only between bytes.
module dma_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          hold_req,
    input logic          hold_ack,
    input logic          addr_oe,
    input logic          addr_stb,
    input logic          dev_ack,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          io_rd,
    input logic          io_wr,
    input logic          done,
    input logic [AW-1:0] cur_addr
);

    // Address drive begins only after a sampled grant.
    p_grant_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe) |-> $past(hold_ack));

    // The latch strobe follows an address-only cycle and lasts one cycle.
    p_stb_after_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_stb) |-> $past(addr_oe) && !$past(dev_ack));
    p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |=> !addr_stb);

    // Exactly one direction pair is active during acknowledge.
    p_dir_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> ((io_rd && mem_wr && !mem_rd && !io_wr) ||
                     (mem_rd && io_wr && !io_rd && !mem_wr)));
    p_no_stray_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_ack |-> !(mem_rd || mem_wr || io_rd || io_wr));

    // The bus is released right after each byte and held off until the grant drops.
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_ack) |-> !hold_req);
    p_wait_grant_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_req && hold_ack) |=> !hold_req);

    // Each finished byte advances the address by exactly one, modulo the page.
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_ack) |-> (cur_addr == AW'($past(cur_addr) + 1'b1)));

    // Once done and idle, no new bus request unless reprogrammed.
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hold_req && !cfg_we) |=> !hold_req);

endmodule

bind dma_single_seq dma_seq_chk #(.AW(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .hold_req (hold_req),
    .hold_ack (hold_ack),
    .addr_oe  (addr_oe),
    .addr_stb (addr_stb),
    .dev_ack  (dev_ack),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .done     (done),
    .cur_addr (cur_addr)
);

// File: tb/test_dma_single_seq.sv
module test_dma_single_seq;
    import dma_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int XCLKS      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        dev_req = 1'b0;
    logic        hold_ack = 1'b0;
    logic        dev_ack, hold_req, addr_oe, addr_stb;
    logic        mem_rd, mem_wr, io_rd, io_wr, done, bound_err;
    logic [15:0] mem_addr;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Bus model and monitor state
    int          req_mode = 0;
    int          lat_max = 2;
    int          lat = 0;
    int          lat_tgt = 0;
    int          since_ack = -1;
    int          ack_len = 0;
    int          bytes = 0;
    int          rises = 0;
    bit          hold_seen = 0;
    bit          prev_ack = 0, prev_hreq = 0, prev_oe = 0, prev_stb = 0;
    logic [15:0] exp_addr = 16'd0;
    logic        exp_dir = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_single_seq i_dma_single_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dev_req(dev_req), .dev_ack(dev_ack),
        .hold_req(hold_req), .hold_ack(hold_ack), .mem_addr(mem_addr),
        .addr_oe(addr_oe), .addr_stb(addr_stb), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .done(done),
        .bound_err(bound_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_bound(input logic [15:0] a, input logic [15:0] n);
        return ({1'b0, a} + {1'b0, n}) > 17'h10000;
    endfunction

    function automatic logic [3:0] exp_strobes(input logic d);
        // order {mem_rd, mem_wr, io_rd, io_wr}
        return d ? 4'b1001 : 4'b0110;
    endfunction

    // Monitor first, then drive the CPU grant and device request, each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (hold_req) hold_seen = 1;
                if (hold_req && !prev_hreq) rises++;
                if (hold_req)
                    chk(hold_ack || !(addr_oe || addr_stb || dev_ack || mem_rd || mem_wr || io_rd || io_wr),
                        "R2 bus drive before grant", {28'd0, addr_oe, addr_stb, dev_ack, 1'b0}, 32'd0);
                if (hold_ack && since_ack < 0) since_ack = 0;
                else if (hold_ack) since_ack++;
                else since_ack = -1;
                if (!addr_oe)
                    chk(mem_addr == 16'd0, "R6 idle address", mem_addr, 0);
                if (addr_stb) begin
                    chk(since_ack == 1, "R3 strobe delay after grant", since_ack, 1);
                    chk(prev_oe && !prev_stb, "R3 address cycle before strobe", {prev_oe, prev_stb}, 2'b10);
                    chk(mem_addr == exp_addr, "R6 strobe address", mem_addr, exp_addr);
                end
                if (dev_ack) begin
                    ack_len++;
                    chk({mem_rd, mem_wr, io_rd, io_wr} == exp_strobes(exp_dir), "R4 strobes",
                        {mem_rd, mem_wr, io_rd, io_wr}, exp_strobes(exp_dir));
                    chk(addr_oe && mem_addr == exp_addr, "R3 address held", mem_addr, exp_addr);
                end
                if (prev_ack && !dev_ack) begin
                    chk(ack_len == XCLKS, "R3 ack length", ack_len, XCLKS);
                    chk(!hold_req, "R5 release after byte", hold_req, 0);
                    bytes++;
                    exp_addr = exp_addr + 16'd1;
                    ack_len = 0;
                end
            end
            prev_ack = dev_ack; prev_hreq = hold_req; prev_oe = addr_oe; prev_stb = addr_stb;
            // CPU grant model with random latency
            if (!hold_req) begin
                hold_ack = 1'b0;
                lat = 0;
                lat_tgt = $urandom_range(0, lat_max);
            end else if (!hold_ack) begin
                if (lat >= lat_tgt) hold_ack = 1'b1;
                else lat++;
            end
            case (req_mode)
                0: dev_req = 1'b0;
                1: dev_req = 1'b1;
                default: dev_req = ($urandom_range(0, 3) != 0);
            endcase
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_xfer(input logic [15:0] a, input logic [15:0] n, input logic d, input int mode);
        bit e;
        e = exp_bound(a, n);
        cfg_write(SEL_ADDR, a);
        cfg_write(SEL_CNT, n);
        exp_addr = a; exp_dir = d; bytes = 0; rises = 0;
        cfg_write(SEL_CTRL, {14'd0, 1'b1, d});
        chk(bound_err == e, "R8 flag at arm", bound_err, e);
        if (n == 16'd0) chk(done == 1'b1, "R7 zero count done at arm", done, 1);
        req_mode = mode;
        for (int i = 0; i < 200 * (n + 1) && !done; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        req_mode = 1; hold_seen = 0;
        repeat (20) @(negedge clk);
        chk(!hold_seen, "R7 requests ignored when done", hold_seen, 0);
        chk(bytes == n, "R7 byte count", bytes, n);
        chk(done == 1'b1, "R7 done flag", done, 1);
        chk(rises == n, "R5 one tenure per byte", rises, n);
        chk(exp_addr == a + n, "R6 final address wrap", exp_addr, a + n);
        chk(bound_err == e, "R8 flag kept", bound_err, e);
        req_mode = 0;
        cfg_write(SEL_CTRL, 16'd0);
        chk(!done && !bound_err, "R9 disarm clears flags", {done, bound_err}, 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog all requirements: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk({hold_req, addr_oe, addr_stb, dev_ack, mem_rd, mem_wr, io_rd, io_wr, done, bound_err} == 10'd0 && mem_addr == 16'd0,
            "R1 outputs in reset", {hold_req, addr_oe, dev_ack, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!hold_req && !done && !bound_err, "R1 outputs after reset", {hold_req, done, bound_err}, 0);

        // Not armed: requests ignored (R7)
        req_mode = 1; hold_seen = 0;
        repeat (20) @(negedge clk);
        chk(!hold_seen, "R7 ignored when not armed", hold_seen, 0);
        req_mode = 0;

        // Directed: device to memory, steady request, then a slow grant (R2)
        run_xfer(16'h1230, 16'd5, 1'b0, 1);
        lat_max = 9;
        run_xfer(16'h4000, 16'd3, 1'b1, 1);
        lat_max = 2;
        // Page wrap with flag (R6, R8)
        run_xfer(16'hFFFE, 16'd4, 1'b1, 2);
        // Zero count (R7)
        run_xfer(16'h0100, 16'd0, 1'b0, 1);
        // Exact page end is not flagged, one more is (R8, R9)
        cfg_write(SEL_ADDR, 16'hF000);
        cfg_write(SEL_CNT, 16'h1000);
        cfg_write(SEL_CTRL, 16'h0002);
        chk(bound_err == 1'b0, "R8 exact page end", bound_err, 0);
        cfg_write(SEL_CNT, 16'h1001);
        cfg_write(SEL_CTRL, 16'h0002);
        chk(bound_err == 1'b1, "R8 one past page end", bound_err, 1);
        cfg_write(SEL_CTRL, 16'h0000);
        req_mode = 1; hold_seen = 0;
        repeat (15) @(negedge clk);
        chk(!hold_seen && !bound_err, "R9 disarm stops requests", {hold_seen, bound_err}, 0);
        req_mode = 0;

        // Random runs
        for (int k = 0; k < 8; k++) begin
            logic [15:0] ra;
            ra = (k % 2 == 0) ? 16'($urandom) : 16'(16'hFFF8 + $urandom_range(0, 7));
            run_xfer(ra, 16'($urandom_range(1, 9)), 1'($urandom_range(0, 1)), 2);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule